// File: doc/BRIEF.md
# Four-Beat Burst SRAM with Posted Writes

This block models a pipelined burst memory behind a double-data-rate style port. The port runs on one clock. Each half-cycle beat of the data bus appears as one of two words per cycle: an even word and an odd word. A command carries one word address and always moves four words. The block forms the other three addresses itself. It counts the two low address bits upward with wrap-around, so a burst never leaves its aligned group of four words.

Write data is not stored in the array straight away. It goes into a holding buffer that keeps one complete burst, its row address and its byte enables. The buffer is emptied into the array when the next write is accepted or in the first free cycle. A read always returns the newest data in program order. When a read targets a row that the buffer still holds, the enabled bytes from the buffer are laid over the array contents. Each byte lane has its own active-low write select.

A command takes two cycles on the data bus, so the port accepts at most one command every other cycle. While it is busy it lowers a ready output. A cycle without a command leaves the read bus idle.

Top module: `burst_ddr_sram`

## Requirements
- R1: After reset `cmd_ready` is 1, `rd_valid` is 0, and every word of the array reads as zero.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 for exactly the one cycle after an acceptance. A command presented in that cycle is dropped and causes no read data and no change to stored data.
- R3: Beat k (k = 0..3) of a burst accesses the word whose upper address bits equal those of `cmd_addr` and whose two low bits are (`cmd_addr[1:0]` + k) mod 4.
- R4: For a write, beats 0 and 1 are taken from `wr_even` and `wr_odd` in the command cycle. Beats 2 and 3 are taken from the same ports in the following cycle.
- R5: For a read accepted at clock edge n, `rd_valid` is 1 in the cycle after edge n+1, carrying beats 0 and 1 on `rd_even`/`rd_odd`. It is also 1 in the cycle after edge n+2, carrying beats 2 and 3.
- R6: `wr_sel_n` bit i (i < bytes per word) controls byte lane i (bits 8i+7..8i) of the even word. Bit i + bytes per word controls the same lane of the odd word. A value of 0 writes the byte. A value of 1 leaves the stored byte unchanged.
- R7: Write data is held in a one-burst posted buffer. It is committed to the array when the next write is accepted, or at the first edge where no command is accepted and the port is not busy. Reads return data in program order across any number of commits.
- R8: A read of a row still held in the posted buffer returns the buffered enabled bytes merged over the array contents. This includes a read issued immediately after the write.
- R9: Without an accepted read, `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | AW | Starting word address |
| cmd_ready | output | 1 | Port can accept a command this cycle |
| wr_even | input | DW | Even-beat write word |
| wr_odd | input | DW | Odd-beat write word |
| wr_sel_n | input | 2*DW/8 | Active-low byte write selects, even lanes low half |
| rd_valid | output | 1 | Read beats are present |
| rd_even | output | DW | Even-beat read word |
| rd_odd | output | DW | Odd-beat read word |

## Verification
Two functions can fall on the same clock edge when a write follows another write: the buffered burst is committed to the array, and the new burst is loaded into the buffer. If a read of that row follows, it sees array data and forwarded buffer data in the same lookup. The bench provokes this with back-to-back writes to one row using different byte masks, then a read straight after. It also reaches the case in a long random run confined to a few rows. Each read result is judged against a behavioural word array that applies every enabled byte at the moment its beat is sampled.

// File: rtl/bsram_pkg.sv
// Shared constants and helpers for the burst SRAM.
// Assumes a fixed burst length of four words, wrapping inside the
// aligned group selected by the upper address bits.
package bsram_pkg;
    localparam int BURST_LEN = 4;

    // Low address bits of a given beat inside a wrapping burst.
    function automatic logic [1:0] beat_slot(input logic [1:0] start, input logic [1:0] beat);
        return start + beat;
    endfunction
endpackage

// File: rtl/bsram_row_array.sv
// Storage array organised as rows of four words with per-byte write enables.
// Assumes one row write per cycle and an asynchronous-style combinational
// read port; contents are cleared by the synchronous reset.
module bsram_row_array #(
    parameter int ROWS  = 64,
    parameter int ROW_W = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(ROWS)-1:0]  waddr,
    input  logic [ROW_W-1:0]         wdata,
    input  logic [ROW_W/8-1:0]       wbe,
    input  logic [$clog2(ROWS)-1:0]  raddr,
    output logic [ROW_W-1:0]         rdata
);
    localparam int ROW_BYTES = ROW_W / 8;

    logic [ROW_W-1:0] mem [ROWS];

    // Clear on reset, otherwise write the enabled bytes of one row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= '0;
            end
        end else if (we) begin
            for (int b = 0; b < ROW_BYTES; b++) begin
                if (wbe[b]) begin
                    mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    end

    // Combinational row read.
    assign rdata = mem[raddr];
endmodule

// File: rtl/bsram_post_buf.sv
// Posted-write buffer holding one burst: row, four word slots and byte enables.
// Slot s holds the word whose two low address bits equal s.
// Assumes load and fill never occur together (fill is the cycle after load).
module bsram_post_buf
    import bsram_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [RW-1:0]         load_row,
    input  logic [1:0]            load_start,
    input  logic                  fill,
    input  logic [DW-1:0]         d_even,
    input  logic [DW-1:0]         d_odd,
    input  logic [2*(DW/8)-1:0]   sel_n,
    input  logic                  commit,
    output logic                  buf_valid,
    output logic [RW-1:0]         buf_row,
    output logic [BURST_LEN*DW-1:0]     buf_data,
    output logic [BURST_LEN*(DW/8)-1:0] buf_be
);
    localparam int NB = DW / 8;

    logic [1:0] start_q;

    // Track occupancy: a load claims the buffer, a commit alone frees it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_row   <= '0;
            start_q   <= '0;
        end else if (load) begin
            buf_valid <= 1'b1;
            buf_row   <= load_row;
            start_q   <= load_start;
        end else if (commit) begin
            buf_valid <= 1'b0;
        end
    end

    // Place beats 0/1 on load and beats 2/3 on fill into their address slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
            buf_be   <= '0;
        end else begin
            for (int s = 0; s < BURST_LEN; s++) begin
                if (load) begin
                    if (2'(s) == beat_slot(load_start, 2'd0)) begin
                        buf_data[s*DW +: DW] <= d_even;
                        buf_be[s*NB +: NB]   <= ~sel_n[NB-1:0];
                    end else if (2'(s) == beat_slot(load_start, 2'd1)) begin
                        buf_data[s*DW +: DW] <= d_odd;
                        buf_be[s*NB +: NB]   <= ~sel_n[2*NB-1:NB];
                    end else begin
                        buf_be[s*NB +: NB]   <= '0;
                    end
                end else if (fill) begin
                    if (2'(s) == beat_slot(start_q, 2'd2)) begin
                        buf_data[s*DW +: DW] <= d_even;
                        buf_be[s*NB +: NB]   <= ~sel_n[NB-1:0];
                    end else if (2'(s) == beat_slot(start_q, 2'd3)) begin
                        buf_data[s*DW +: DW] <= d_odd;
                        buf_be[s*NB +: NB]   <= ~sel_n[2*NB-1:NB];
                    end
                end
            end
        end
    end

    // R7
    commit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> buf_valid);

    // R4
    fill_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> fill);
endmodule

// File: rtl/bsram_rd_pipe.sv
// Read pipeline: holds the burst start, merges the posted buffer over the
// array row and presents two words per cycle over two cycles.
// Assumes starts are at least two cycles apart and the array read is
// combinational on rd_row.
module bsram_rd_pipe
    import bsram_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [RW-1:0]         start_row,
    input  logic [1:0]            start_lo,
    output logic [RW-1:0]         rd_row,
    input  logic [BURST_LEN*DW-1:0]     arr_row,
    input  logic                  buf_valid,
    input  logic [RW-1:0]         buf_row,
    input  logic [BURST_LEN*DW-1:0]     buf_data,
    input  logic [BURST_LEN*(DW/8)-1:0] buf_be,
    output logic                  rd_valid,
    output logic [DW-1:0]         rd_even,
    output logic [DW-1:0]         rd_odd
);
    localparam int ROW_W     = BURST_LEN * DW;
    localparam int ROW_BYTES = ROW_W / 8;

    logic [1:0]       lo_q;
    logic             ph1, ph2;
    logic             hit;
    logic [ROW_W-1:0] merged;
    logic [1:0]       i0, i1, i2, i3;

    assign hit = buf_valid && (buf_row == rd_row);

    // Byte-wise forwarding of the newer buffered bytes over the array row.
    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_merge
        assign merged[b*8 +: 8] = (hit && buf_be[b]) ? buf_data[b*8 +: 8] : arr_row[b*8 +: 8];
    end

    assign i0 = beat_slot(lo_q, 2'd0);
    assign i1 = beat_slot(lo_q, 2'd1);
    assign i2 = beat_slot(lo_q, 2'd2);
    assign i3 = beat_slot(lo_q, 2'd3);

    // Capture the burst address and advance the two-phase output sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_row <= '0;
            lo_q   <= '0;
            ph1    <= 1'b0;
            ph2    <= 1'b0;
        end else begin
            ph1 <= start;
            ph2 <= ph1;
            if (start) begin
                rd_row <= start_row;
                lo_q   <= start_lo;
            end
        end
    end

    // Register the beat pair for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_even  <= '0;
            rd_odd   <= '0;
        end else if (ph1) begin
            rd_valid <= 1'b1;
            rd_even  <= merged[i0*DW +: DW];
            rd_odd   <= merged[i1*DW +: DW];
        end else if (ph2) begin
            rd_valid <= 1'b1;
            rd_even  <= merged[i2*DW +: DW];
            rd_odd   <= merged[i3*DW +: DW];
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // R5
    rd_pair_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid);

    // R2
    start_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/burst_ddr_sram.sv
// Burst SRAM top: command acceptance, posted-write commit policy and wiring
// of the buffer, read pipeline and array.
// Assumes a single clock; even/odd words stand for the two half-cycle beats.
module burst_ddr_sram
    import bsram_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic [AW-1:0]        cmd_addr,
    output logic                 cmd_ready,
    input  logic [DW-1:0]        wr_even,
    input  logic [DW-1:0]        wr_odd,
    input  logic [2*(DW/8)-1:0]  wr_sel_n,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_even,
    output logic [DW-1:0]        rd_odd
);
    localparam int NB    = DW / 8;
    localparam int RW    = AW - 2;
    localparam int ROWS  = 2 ** RW;
    localparam int ROW_W = BURST_LEN * DW;

    logic             busy, busy_wr;
    logic             accept, load, rd_start, commit;
    logic             buf_valid;
    logic [RW-1:0]    buf_row, rd_row;
    logic [ROW_W-1:0] buf_data, arr_row;
    logic [BURST_LEN*NB-1:0] buf_be;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && !busy;
    assign load      = accept && cmd_write;
    assign rd_start  = accept && !cmd_write;
    assign commit    = buf_valid && (load || (!accept && !busy));

    // Mark the second cycle of every burst; remember if it carries write beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            busy_wr <= 1'b0;
        end else begin
            busy    <= accept;
            busy_wr <= load;
        end
    end

    bsram_post_buf #(.DW(DW), .RW(RW)) u_post_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_row  (cmd_addr[AW-1:2]),
        .load_start(cmd_addr[1:0]),
        .fill      (busy_wr),
        .d_even    (wr_even),
        .d_odd     (wr_odd),
        .sel_n     (wr_sel_n),
        .commit    (commit),
        .buf_valid (buf_valid),
        .buf_row   (buf_row),
        .buf_data  (buf_data),
        .buf_be    (buf_be)
    );

    bsram_row_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (commit),
        .waddr(buf_row),
        .wdata(buf_data),
        .wbe  (buf_be),
        .raddr(rd_row),
        .rdata(arr_row)
    );

    bsram_rd_pipe #(.DW(DW), .RW(RW)) u_rd_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rd_start),
        .start_row(cmd_addr[AW-1:2]),
        .start_lo (cmd_addr[1:0]),
        .rd_row   (rd_row),
        .arr_row  (arr_row),
        .buf_valid(buf_valid),
        .buf_row  (buf_row),
        .buf_data (buf_data),
        .buf_be   (buf_be),
        .rd_valid (rd_valid),
        .rd_even  (rd_even),
        .rd_odd   (rd_odd)
    );

    // R2
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !busy && !accept) |=> !rd_valid);
endmodule

// File: tb/burst_ddr_sram_bench.sv
module burst_ddr_sram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int NB = DW / 8;

    logic clk = 1'b0;
    logic rst_n;
    logic cmd_valid, cmd_write;
    logic [AW-1:0] cmd_addr;
    logic cmd_ready;
    logic [DW-1:0] wr_even, wr_odd;
    logic [2*NB-1:0] wr_sel_n;
    logic rd_valid;
    logic [DW-1:0] rd_even, rd_odd;

    burst_ddr_sram #(.DW(DW), .AW(AW)) u_burst_ddr_sram (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .wr_even(wr_even),
        .wr_odd(wr_odd), .wr_sel_n(wr_sel_n), .rd_valid(rd_valid),
        .rd_even(rd_even), .rd_odd(rd_odd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {int due; logic [DW-1:0] ev; logic [DW-1:0] od;} exp_t;

    logic [DW-1:0] ref_mem [2**AW];
    exp_t          expq [$];
    int            cyc = 0, n_cmp = 0, n_bad = 0;
    bit            model_busy = 0, fill_pend = 0, finished = 0;
    logic [AW-1:0] fill_addr;
    string         req = "R1";

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] a, int k);
        return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
    endfunction

    task automatic put_beat(logic [AW-1:0] a, int k, logic [DW-1:0] d, logic [NB-1:0] sn);
        logic [AW-1:0] w = beat_addr(a, k);
        for (int b = 0; b < NB; b++)
            if (!sn[b]) ref_mem[w][b*8 +: 8] = d[b*8 +: 8];
    endtask

    // Compare outputs for the edge just passed, then drive the next edge.
    task automatic step(bit v, bit w, logic [AW-1:0] a, logic [DW-1:0] de, logic [DW-1:0] dd,
                        logic [2*NB-1:0] sn);
        bit acc;
        check("R2", "cmd_ready", {31'b0, cmd_ready}, {31'b0, !model_busy});
        if (expq.size() > 0 && expq[0].due == cyc) begin
            check("R5", "rd_valid", {31'b0, rd_valid}, 1);
            check(req, "rd_even", rd_even, expq[0].ev);
            check(req, "rd_odd", rd_odd, expq[0].od);
            void'(expq.pop_front());
        end else begin
            check("R9", "rd_valid idle", {31'b0, rd_valid}, 0);
        end
        cmd_valid = v; cmd_write = w; cmd_addr = a;
        wr_even = de; wr_odd = dd; wr_sel_n = sn;
        acc = v && !model_busy;
        if (fill_pend) begin
            put_beat(fill_addr, 2, de, sn[NB-1:0]);
            put_beat(fill_addr, 3, dd, sn[2*NB-1:NB]);
            fill_pend = 0;
        end
        if (acc && w) begin
            put_beat(a, 0, de, sn[NB-1:0]);
            put_beat(a, 1, dd, sn[2*NB-1:NB]);
            fill_pend = 1; fill_addr = a;
        end else if (acc) begin
            expq.push_back('{cyc + 2, ref_mem[beat_addr(a, 0)], ref_mem[beat_addr(a, 1)]});
            expq.push_back('{cyc + 2 + 1, ref_mem[beat_addr(a, 2)], ref_mem[beat_addr(a, 3)]});
        end
        model_busy = acc;
        @(posedge clk); cyc++; @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d0, logic [DW-1:0] d1,
                      logic [DW-1:0] d2, logic [DW-1:0] d3, logic [2*NB-1:0] s01, logic [2*NB-1:0] s23);
        step(1, 1, a, d0, d1, s01);
        step(0, 0, '0, d2, d3, s23);
    endtask

    task automatic rd(logic [AW-1:0] a);
        step(1, 0, a, '0, '0, '1);
        step(0, 0, '0, '0, '0, '1);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, '1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2**AW; i++) ref_mem[i] = '0;
        rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_addr = '0;
        wr_even = '0; wr_odd = '0; wr_sel_n = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "cmd_ready reset", {31'b0, cmd_ready}, 1);
        check("R1", "rd_valid reset", {31'b0, rd_valid}, 0);
        rst_n = 1;
        @(posedge clk); @(negedge clk);

        req = "R1";  rd(8'h40); idle(3);
        // R3 aligned start, full-word write, drained by idle cycles
        req = "R3";  wr(8'h10, 32'hA0A0_0000, 32'hA1A1_0001, 32'hA2A2_0002, 32'hA3A3_0003, '0, '0);
        idle(2); rd(8'h10); idle(2);
        // R3 wrapped start
        rd(8'h13); idle(2);
        // R8 write then immediate read from the buffer, wrapped start 01
        req = "R8";  wr(8'h21, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444, '0, '0);
        rd(8'h22); idle(3);
        // R6 partial masks over existing row, read back while still buffered
        req = "R6";  wr(8'h10, 32'hFFFF_FFFF, 32'hEEEE_EEEE, 32'hDDDD_DDDD, 32'hCCCC_CCCC, 8'b0101_1010, 8'b1111_0000);
        rd(8'h10); idle(3); rd(8'h11); idle(3);
        // R7 back-to-back writes to one row: commit and reload on the same edge
        req = "R7";  wr(8'h30, 32'h0101_0101, 32'h0202_0202, 32'h0303_0303, 32'h0404_0404, '0, '0);
        wr(8'h32, 32'h5500_0055, 32'h6600_0066, 32'h7700_0077, 32'h8800_0088, 8'b0110_1001, 8'b1001_0110);
        rd(8'h30); rd(8'h33); idle(3);
        // R4 beat timing: distinct words per beat, different row
        req = "R4";  wr(8'h47, 32'hB000_0000, 32'hB000_0001, 32'hB000_0002, 32'hB000_0003, '0, '0);
        wr(8'h50, 32'hC0, 32'hC1, 32'hC2, 32'hC3, '0, '0);
        rd(8'h44); rd(8'h50); idle(3);
        // R2 command during busy cycle is dropped (read and write)
        req = "R2";  step(1, 0, 8'h10, '0, '0, '1); step(1, 0, 8'h20, '0, '0, '1); idle(3);
        step(1, 0, 8'h30, '0, '0, '1); step(1, 1, 8'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF, '0); idle(2);
        rd(8'h10); idle(3);
        // R9 deselect stretch
        req = "R9";  idle(6);
        // Random program-order run on a few rows
        req = "R7";
        for (int it = 0; it < 600; it++) begin
            int r = $urandom % 4;
            logic [AW-1:0] a = AW'($urandom % 16) | 8'h60;
            if (r == 0) idle(1);
            else if (r == 1)
                wr(a, $urandom, $urandom, $urandom, $urandom, 2*NB'($urandom), 2*NB'($urandom));
            else if (r == 2) rd(a);
            else begin
                step(1, 0, a, '0, '0, '1);
                step($urandom % 2 == 0, $urandom % 2 == 0, AW'($urandom), $urandom, $urandom, '0);
            end
        end
        idle(6);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule